// File: doc/BRIEF.md
# Double-Buffered Parallel Converter Code Register

This block is the digital front end of a 12-bit voltage-output converter, clocked by one system clock. An external controller drives a parallel bus with no relation to that clock. The bus carries twelve data lines and four active-low controls: select, write strobe, load strobe and power. Every bus line passes through a two-flop synchroniser. All edges are found from the synchronised levels.

A write strobe rising edge, seen while select is low, copies the data word into a holding register. The converter latch takes the holding value only while the load strobe is low. The load strobe is independent of the write strobe, so a new word can wait in the holding register until an agreed moment. Holding the load strobe low makes the latch track each new holding value. The block also computes an ideal output value in reference units, where the reference is a digital input word. While the power input is low the block raises a power-down flag and reports zero, but it keeps both registers.

The bus timing rules are expressed as minimum cycle counts. Each rule has its own sticky violation flag, which a clear input resets.

Top module: `pdac_front`

## Requirements
- R1: After reset the latched code, the reported output value and all violation flags are zero, and the power-down flag is low.
- R2: A write strobe rising edge with select low loads the data word into the holding register, with data bit 0 as the LSB. A rising edge with select high leaves the holding register unchanged.
- R3: The latch copies the holding register only while the load strobe is low. While the load strobe is high, writes do not change the latched code.
- R4: While the load strobe is held low, the latch follows every new holding value, at most four clocks after the write strobe rises.
- R5: While the power input is low, the power-down flag is 1 and the reported value is 0, and the latched code is kept. Releasing the power input restores the value of the latched code.
- R6: The reported value is floor(vref × code / 2048), straight binary. Code 0 gives 0, code 2048 gives exactly vref, and code 4095 gives floor(vref × 4095 / 2048).
- R7: Violation flag bit 0 is set when a capturing write edge comes fewer than CS_MIN synchronised cycles after select went low.
- R8: Violation flag bit 1 is set when the data word changed fewer than DS_MIN cycles before a capturing write edge.
- R9: Violation flag bit 2 is set when the data word changes within HOLD_CYC cycles after a capturing write edge. A change later than that sets nothing.
- R10: Violation flag bit 3 is set when the write strobe falls after being high for fewer than WR_HI_MIN cycles.
- R11: Violation flag bit 4 is set when the load strobe rises after being low for fewer than LD_LO_MIN cycles.
- R12: Violation flag bit 5 is set when the load strobe falls while the write strobe is low.
- R13: Violation flags stay set until the clear input is high for a clock edge. A clear then returns them to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_d | input | 12 | Parallel data word, bit 0 is the LSB |
| sel_n | input | 1 | Active-low select |
| wr_n | input | 1 | Active-low write strobe, captures on its rising edge |
| ld_n | input | 1 | Active-low load strobe, transfers holding to latch while low |
| pwr_n | input | 1 | Active-low power-down request |
| vref | input | 12 | Reference value used for scaling |
| viol_clr | input | 1 | Synchronous clear of the sticky violation flags |
| code_q | output | 12 | Latched converter code |
| pd_flag | output | 1 | High while powered down |
| vout | output | 13 | Ideal output value, zero in power-down |
| viol_flags | output | 6 | Sticky timing violation flags |

## Verification
The assertions check three rules on every cycle. The holding register moves only after a qualified write edge. The latch stays frozen while the load strobe is high, and it follows the holding register while the strobe is low. Violation flags never drop without a clear. They also check the mid-scale code against the reference, and that a load falling edge during a low write strobe is always flagged. Other behaviour shows only in the bench's scenarios: retention across power-down, the scaling at the ends of the code range, and the exact cycle boundary of each timing rule, where one cycle less must set a flag and the limit itself must not.

// File: rtl/pdac_pkg.sv
package pdac_pkg;
  localparam int unsigned NVIOL  = 6;
  localparam int unsigned VB_CS  = 0;  // select setup before write edge
  localparam int unsigned VB_DSU = 1;  // data setup before write edge
  localparam int unsigned VB_DHO = 2;  // data hold after write edge
  localparam int unsigned VB_WRW = 3;  // write strobe high width
  localparam int unsigned VB_LDW = 4;  // load strobe low width
  localparam int unsigned VB_ORD = 5;  // load falls while write low
endpackage

// File: rtl/pdac_sync.sv
module pdac_sync #(
  parameter int unsigned    W       = 1,
  parameter logic [W-1:0]   RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= RST_VAL;
      q      <= RST_VAL;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end
endmodule

// File: rtl/pdac_age.sv
module pdac_age #(
  parameter int unsigned  W       = 1,
  parameter int unsigned  CW      = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [W-1:0]  sig,
  output logic          chg,
  output logic [CW-1:0] age_now,
  output logic [CW-1:0] run_prev
);
  logic [W-1:0]  sig_d;
  logic [CW-1:0] age_q, age_nx;

  always_comb begin
    chg     = (sig != sig_d);
    age_now = chg ? '0 : age_q;
    age_nx  = (age_now == {CW{1'b1}}) ? age_now : age_now + 1'b1;
  end

  assign run_prev = age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sig_d <= RST_VAL;
      age_q <= '1;
    end else begin
      sig_d <= sig;
      age_q <= age_nx;
    end
  end
endmodule

// File: rtl/pdac_regs.sv
module pdac_regs #(
  parameter int unsigned DW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap,
  input  logic [DW-1:0] din,
  input  logic          ld_on,
  output logic [DW-1:0] hold_q,
  output logic [DW-1:0] latch_q
);
  logic [DW-1:0] hold_nx, latch_nx;
  logic          hold_en, latch_en;

  always_comb begin
    hold_en  = cap;
    hold_nx  = din;
    latch_en = ld_on;
    latch_nx = hold_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q  <= '0;
      latch_q <= '0;
    end else begin
      if (hold_en)  hold_q  <= hold_nx;
      if (latch_en) latch_q <= latch_nx;
    end
  end

  // R2
  hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cap |=> $stable(hold_q));
  // R3
  latch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_on |=> $stable(latch_q));
  // R4
  latch_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ld_on |=> (latch_q == $past(hold_q)));
endmodule

// File: rtl/pdac_timing.sv
module pdac_timing
  import pdac_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter int unsigned CW        = 3,
  parameter int unsigned CS_MIN    = 2,
  parameter int unsigned DS_MIN    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned WR_HI_MIN = 2,
  parameter int unsigned LD_LO_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sel_s,
  input  logic             wr_s,
  input  logic             ld_s,
  input  logic [DW-1:0]    dat_s,
  input  logic             clr,
  output logic             cap,
  output logic             ld_on,
  output logic [NVIOL-1:0] viol_q
);
  localparam logic [CW-1:0] CS_L   = CW'(CS_MIN);
  localparam logic [CW-1:0] DS_L   = CW'(DS_MIN);
  localparam logic [CW-1:0] HOLD_L = CW'(HOLD_CYC);
  localparam logic [CW-1:0] WR_L   = CW'(WR_HI_MIN);
  localparam logic [CW-1:0] LD_L   = CW'(LD_LO_MIN);

  logic          sel_chg, wr_chg, ld_chg, dat_chg;
  logic [CW-1:0] sel_age, wr_age, ld_age, dat_age;
  logic [CW-1:0] sel_run, wr_run, ld_run, dat_run;
  logic [NVIOL-1:0] ev, viol_nx;

  pdac_age #(.W(1),  .CW(CW), .RST_VAL(1'b1)) u_age_sel (
    .clk(clk), .rst_n(rst_n), .sig(sel_s), .chg(sel_chg), .age_now(sel_age), .run_prev(sel_run));
  pdac_age #(.W(1),  .CW(CW), .RST_VAL(1'b1)) u_age_wr (
    .clk(clk), .rst_n(rst_n), .sig(wr_s), .chg(wr_chg), .age_now(wr_age), .run_prev(wr_run));
  pdac_age #(.W(1),  .CW(CW), .RST_VAL(1'b1)) u_age_ld (
    .clk(clk), .rst_n(rst_n), .sig(ld_s), .chg(ld_chg), .age_now(ld_age), .run_prev(ld_run));
  pdac_age #(.W(DW), .CW(CW), .RST_VAL('0)) u_age_dat (
    .clk(clk), .rst_n(rst_n), .sig(dat_s), .chg(dat_chg), .age_now(dat_age), .run_prev(dat_run));

  always_comb begin
    cap   = wr_chg & wr_s & ~sel_s;
    ld_on = ~ld_s;
    ev = '0;
    ev[VB_CS]  = cap && (sel_age < CS_L);
    ev[VB_DSU] = cap && (dat_age < DS_L);
    ev[VB_DHO] = dat_chg && wr_s && !sel_s && (wr_age != '0) && (wr_age <= HOLD_L);
    ev[VB_WRW] = wr_chg && !wr_s && (wr_run < WR_L);
    ev[VB_LDW] = ld_chg && ld_s && (ld_run < LD_L);
    ev[VB_ORD] = ld_chg && !ld_s && !wr_s;
    viol_nx = (clr ? '0 : viol_q) | ev;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) viol_q <= '0;
    else        viol_q <= viol_nx;
  end

  // R13
  viol_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((viol_q & $past(viol_q)) == $past(viol_q)));
  // R12
  ld_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(ld_s) && !wr_s) |=> viol_q[VB_ORD]);
endmodule

// File: rtl/pdac_front.sv
module pdac_front
  import pdac_pkg::*;
#(
  parameter int unsigned DW        = 12,
  parameter int unsigned RW        = 12,
  parameter int unsigned CS_MIN    = 2,
  parameter int unsigned DS_MIN    = 2,
  parameter int unsigned HOLD_CYC  = 1,
  parameter int unsigned WR_HI_MIN = 2,
  parameter int unsigned LD_LO_MIN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DW-1:0]    bus_d,
  input  logic             sel_n,
  input  logic             wr_n,
  input  logic             ld_n,
  input  logic             pwr_n,
  input  logic [RW-1:0]    vref,
  input  logic             viol_clr,
  output logic [DW-1:0]    code_q,
  output logic             pd_flag,
  output logic [RW:0]      vout,
  output logic [NVIOL-1:0] viol_flags
);
  localparam int unsigned M1     = (CS_MIN > DS_MIN) ? CS_MIN : DS_MIN;
  localparam int unsigned M2     = (WR_HI_MIN > LD_LO_MIN) ? WR_HI_MIN : LD_LO_MIN;
  localparam int unsigned M3     = (M1 > M2) ? M1 : M2;
  localparam int unsigned MAXMIN = (M3 > HOLD_CYC + 1) ? M3 : HOLD_CYC + 1;
  localparam int unsigned CW     = $clog2(MAXMIN + 2);
  localparam int unsigned PW     = RW + DW;
  localparam logic [DW-1:0] MID  = DW'(1) << (DW - 1);

  logic          rst_m, rst_s;
  logic [3:0]    ctl_s;
  logic [DW-1:0] dat_s, hold_q;
  logic          cap, ld_on;
  logic [PW-1:0] prod;

  // reset: asserted asynchronously, released on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  pdac_sync #(.W(4), .RST_VAL(4'b1111)) u_sync_ctl (
    .clk(clk), .rst_n(rst_s), .d({pwr_n, ld_n, wr_n, sel_n}), .q(ctl_s));
  pdac_sync #(.W(DW), .RST_VAL('0)) u_sync_dat (
    .clk(clk), .rst_n(rst_s), .d(bus_d), .q(dat_s));

  pdac_timing #(
    .DW(DW), .CW(CW), .CS_MIN(CS_MIN), .DS_MIN(DS_MIN), .HOLD_CYC(HOLD_CYC),
    .WR_HI_MIN(WR_HI_MIN), .LD_LO_MIN(LD_LO_MIN)
  ) u_timing (
    .clk(clk), .rst_n(rst_s), .sel_s(ctl_s[0]), .wr_s(ctl_s[1]), .ld_s(ctl_s[2]),
    .dat_s(dat_s), .clr(viol_clr), .cap(cap), .ld_on(ld_on), .viol_q(viol_flags));

  pdac_regs #(.DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_s), .cap(cap), .din(dat_s), .ld_on(ld_on),
    .hold_q(hold_q), .latch_q(code_q));

  always_comb begin
    pd_flag = ~ctl_s[3];
    prod    = PW'(vref) * PW'(code_q);
    vout    = pd_flag ? '0 : prod[DW-1 +: RW+1];
  end

  // R6
  vout_mid_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (code_q == MID && !pd_flag) |-> (vout == {1'b0, vref}));
endmodule

// File: tb/test_pdac_front.sv
module test_pdac_front;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [11:0] bus_d;
  logic        sel_n, wr_n, ld_n, pwr_n, viol_clr;
  logic [11:0] vref;
  logic [11:0] code_q;
  logic        pd_flag;
  logic [12:0] vout;
  logic [5:0]  viol_flags;

  int n_chk = 0;
  int n_fail = 0;
  logic [11:0] exp_hold, exp_code;
  bit follow = 0;

  always #4 clk = ~clk;

  pdac_front i_pdac_front (
    .clk(clk), .rst_n(rst_n), .bus_d(bus_d), .sel_n(sel_n), .wr_n(wr_n),
    .ld_n(ld_n), .pwr_n(pwr_n), .vref(vref), .viol_clr(viol_clr),
    .code_q(code_q), .pd_flag(pd_flag), .vout(vout), .viol_flags(viol_flags));

  function automatic int unsigned ideal(input int unsigned vr, input int unsigned c);
    return (vr * c) >> 11;
  endfunction

  task automatic chk(input bit ok, input string req, input int unsigned act, input int unsigned exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [11:0] d, input logic s);
    bus_d = d; sel_n = s;
    idle(4); wr_n = 1'b0;
    idle(3); wr_n = 1'b1;
    idle(4); sel_n = 1'b1;
    idle(3);
    if (!s) exp_hold = d;
    if (follow) exp_code = exp_hold;
  endtask

  task automatic do_load();
    ld_n = 1'b0; idle(3);
    ld_n = 1'b1; idle(4);
    exp_code = exp_hold;
  endtask

  task automatic clear_flags();
    viol_clr = 1'b1; idle(1);
    viol_clr = 1'b0; idle(1);
  endtask

  task automatic chk_code(input string req);
    chk(code_q == exp_code, req, code_q, exp_code);
    chk(vout == ideal(vref, exp_code), req, vout, ideal(vref, exp_code));
  endtask

  task automatic chk_flags(input string req, input logic [5:0] e);
    chk(viol_flags == e, req, viol_flags, e);
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    rst_n = 1'b0; bus_d = '0; sel_n = 1; wr_n = 1; ld_n = 1; pwr_n = 1;
    viol_clr = 0; vref = 12'd3000;
    exp_hold = '0; exp_code = '0;
    idle(3); rst_n = 1'b1; idle(6);

    // R1 reset state
    chk(code_q == 0, "R1", code_q, 0);
    chk(vout == 0, "R1", vout, 0);
    chk(viol_flags == 0, "R1", viol_flags, 0);
    chk(pd_flag == 0, "R1", pd_flag, 0);

    // R2 bit 0 is the LSB
    do_write(12'h001, 1'b0); do_load();
    chk_code("R2");
    // R3 write with load high leaves the latch alone
    do_write(12'hA5C, 1'b0);
    chk(code_q == 12'h001, "R3", code_q, 12'h001);
    do_load(); chk_code("R3");
    // R2 write with select high ignored
    do_write(12'h3C3, 1'b1); do_load();
    chk(code_q == 12'hA5C, "R2", code_q, 12'hA5C);

    // R6 scaling corners
    do_write(12'd0, 1'b0); do_load();    chk_code("R6");
    do_write(12'd2048, 1'b0); do_load();
    chk(vout == 13'(vref), "R6", vout, vref);
    do_write(12'd4095, 1'b0); do_load();
    chk(vout == 13'd5998, "R6", vout, 5998);

    // R5 power-down retains code
    pwr_n = 1'b0; idle(4);
    chk(pd_flag == 1, "R5", pd_flag, 1);
    chk(vout == 0, "R5", vout, 0);
    chk(code_q == 12'd4095, "R5", code_q, 4095);
    pwr_n = 1'b1; idle(4);
    chk(pd_flag == 0, "R5", pd_flag, 0);
    chk_code("R5");

    // R4 load held low follows each write
    ld_n = 1'b0; idle(4); follow = 1; exp_code = exp_hold;
    for (int i = 0; i < 4; i++) begin
      do_write(12'($urandom), 1'b0);
      chk_code("R4");
    end
    ld_n = 1'b1; follow = 0; idle(4);
    chk_flags("R4", 6'd0);

    // random writes and loads
    for (int i = 0; i < 30; i++) begin
      vref = 12'($urandom);
      do_write(12'($urandom), ($urandom % 4) == 0);
      if ($urandom % 2) do_load();
      chk_code("R3");
      chk_flags("R13", 6'd0);
    end

    // R7 select setup: 1 cycle flags, 2 cycles passes
    bus_d = 12'h111; wr_n = 1'b0; idle(4);
    sel_n = 1'b0; idle(1); wr_n = 1'b1; idle(5); sel_n = 1'b1; idle(3);
    exp_hold = 12'h111;
    chk_flags("R7", 6'b000001);
    idle(10); chk_flags("R13", 6'b000001);
    clear_flags(); chk_flags("R13", 6'd0);
    bus_d = 12'h112; wr_n = 1'b0; idle(4);
    sel_n = 1'b0; idle(2); wr_n = 1'b1; idle(5); sel_n = 1'b1; idle(3);
    exp_hold = 12'h112;
    chk_flags("R7", 6'd0);

    // R8 data setup
    sel_n = 1'b0; wr_n = 1'b0; idle(4);
    bus_d = 12'h222; idle(1); wr_n = 1'b1; idle(5); sel_n = 1'b1; idle(3);
    exp_hold = 12'h222;
    chk_flags("R8", 6'b000010);
    do_load(); chk_code("R8");
    clear_flags();

    // R9 data hold: change one cycle after edge flags, two cycles passes
    bus_d = 12'h333; sel_n = 1'b0; idle(4); wr_n = 1'b0; idle(3);
    wr_n = 1'b1; idle(1); bus_d = 12'h444; idle(5); sel_n = 1'b1; idle(3);
    exp_hold = 12'h333;
    chk_flags("R9", 6'b000100);
    do_load(); chk_code("R9");
    clear_flags();
    bus_d = 12'h555; sel_n = 1'b0; idle(4); wr_n = 1'b0; idle(3);
    wr_n = 1'b1; idle(2); bus_d = 12'h666; idle(5); sel_n = 1'b1; idle(3);
    exp_hold = 12'h555;
    chk_flags("R9", 6'd0);

    // R10 short write-high pulse
    wr_n = 1'b0; idle(3); wr_n = 1'b1; idle(1); wr_n = 1'b0; idle(3); wr_n = 1'b1; idle(5);
    chk_flags("R10", 6'b001000);
    clear_flags();

    // R11 short load-low pulse (still transfers)
    ld_n = 1'b0; idle(1); ld_n = 1'b1; idle(5);
    exp_code = exp_hold;
    chk_flags("R11", 6'b010000);
    chk_code("R11");
    clear_flags();

    // R12 load falls while write low
    wr_n = 1'b0; idle(3); ld_n = 1'b0; idle(3); ld_n = 1'b1; idle(2); wr_n = 1'b1; idle(5);
    chk_flags("R12", 6'b100000);
    clear_flags();
    chk_flags("R13", 6'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule